// File: doc/BRIEF.md
# Coprocessor Interrupt Control Register

This block is a single 16-bit control and status word. It merges three interrupt sources into one interrupt line for the host processor. The sources are the audio stream DMA, the auxiliary-memory DMA and the coprocessor. Each source owns a sticky status flag. The enable for each flag sits in the bit just above it, so the combined line is high whenever a flag and its neighbouring enable are both set.

The same word also holds four control bits that go to the coprocessor: reset, assert-interrupt, halt and init. It carries a read-only busy flag that mirrors the auxiliary-memory DMA engine. Software acknowledges a source by writing 1 to its status bit.

A write that sets the reset bit also sends a one-cycle clear to the audio DMA control word, which lives in another block. A write that puts ones into unused bit positions raises a one-cycle error pulse. The coprocessor itself is outside this block.

Top module: `cop_irq_ctl`

## Requirements
- R1: After reset, `rdData` reads 0x0004 (only the halt bit, bit 2, set), `irqOut` is 0, and `audioCtlClr` and `padError` are 0.
- R2: A pulse on `srcPulse[i]` sets status bit 3+2*i (i=0 audio DMA, bit 3; i=1 auxiliary-memory DMA, bit 5; i=2 coprocessor, bit 7) at the next clock edge. The bit stays set until it is acknowledged.
- R3: A write with a 1 in a status bit position clears that status bit, and a 0 leaves it unchanged. When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R4: A write loads the enable bits (4, 6 and 8) and the control bits (reset 0, assert 1, halt 2, init 11) directly from `wrData`.
- R5: `irqOut` is 1 exactly when some status bit 3+2*i and its enable bit 4+2*i are both set. It follows the register state from the cycle after the write or pulse.
- R6: Bit 9 of `rdData` always shows the live `dmaBusy` input. A write to bit 9 has no effect.
- R7: The unused bits 10 and 12 to 15 always read 0. A write with any 1 in those bits gives a one-cycle `padError` pulse in the following cycle.
- R8: A write with bit 0 set gives a one-cycle `audioCtlClr` pulse in the following cycle. A write with bit 0 clear gives none.
- R9: Without a write, only set pulses change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write value |
| rdData | output | 16 | Current register value |
| srcPulse | input | 3 | Status set pulses: audio DMA, auxiliary-memory DMA, coprocessor |
| dmaBusy | input | 1 | Auxiliary-memory DMA busy flag, shown in bit 9 |
| irqOut | output | 1 | Combined interrupt line |
| audioCtlClr | output | 1 | One-cycle clear for the audio DMA control word |
| padError | output | 1 | One-cycle flag for a write into unused bits |

## Verification
The bench builds the block with the package defaults: a 16-bit word, three sources starting at bit 3, busy at bit 9 and init at bit 11. This layout puts every status/enable pair next to a control bit, next to the busy flag and next to the padding bits. Random writes, pulses and busy values can therefore land on every neighbouring-bit boundary that the layout creates. Directed cases cover a set pulse and a clear landing in the same cycle, writes into the padding, and interrupts gated by their enables.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  localparam int REG_W    = 16;
  localparam int SRC_N    = 3;
  localparam int SRC_BASE = 3;
  localparam int RST_BIT  = 0;
  localparam int ASR_BIT  = 1;
  localparam int HLT_BIT  = 2;
  localparam int BUSY_BIT = SRC_BASE + 2 * SRC_N;
  localparam int INIT_BIT = BUSY_BIT + 2;

  function automatic int statBit(input int idx);
    return SRC_BASE + 2 * idx;
  endfunction

  function automatic logic [REG_W-1:0] usedMask();
    logic [REG_W-1:0] m;
    m = '0;
    m[RST_BIT]  = 1'b1;
    m[ASR_BIT]  = 1'b1;
    m[HLT_BIT]  = 1'b1;
    m[BUSY_BIT] = 1'b1;
    m[INIT_BIT] = 1'b1;
    for (int k = 0; k < SRC_N; k++) begin
      m[statBit(k)]     = 1'b1;
      m[statBit(k) + 1] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] PAD_MASK = ~usedMask();

  typedef struct packed {
    logic             wrStb;
    logic [REG_W-1:0] wrVal;
    logic [SRC_N-1:0] setStat;
    logic [SRC_N-1:0] clrStat;
    logic             padHit;
    logic             rstHit;
  } ctlStrobes_t;
endpackage

// File: rtl/cop_irq_decode.sv
module cop_irq_decode
  import cop_irq_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic [SRC_N-1:0] srcPulse,
  output ctlStrobes_t      strobes
);
  logic [SRC_N-1:0] clrVec;

  for (genvar i = 0; i < SRC_N; i++) begin : g_clr
    assign clrVec[i] = wrEn & wrData[statBit(i)];
  end

  always_comb begin
    strobes.wrStb   = wrEn;
    strobes.wrVal   = wrData;
    strobes.setStat = srcPulse;
    strobes.clrStat = clrVec;
    strobes.padHit  = wrEn & (|(wrData & PAD_MASK));
    strobes.rstHit  = wrEn & wrData[RST_BIT];
  end
endmodule

// File: rtl/cop_irq_datapath.sv
module cop_irq_datapath
  import cop_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             dmaBusy,
  output logic [REG_W-1:0] rdData,
  output logic             irqOut,
  output logic             audioCtlClr,
  output logic             padError
);
  logic [SRC_N-1:0] statReg;
  logic [SRC_N-1:0] maskReg;
  logic rstBit, asrBit, hltBit, initBit;
  logic audioClrQ, padErrQ;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        statReg[i] <= 1'b0;
        maskReg[i] <= 1'b0;
      end else begin
        if (strobes.setStat[i])      statReg[i] <= 1'b1;
        else if (strobes.clrStat[i]) statReg[i] <= 1'b0;
        if (strobes.wrStb) maskReg[i] <= strobes.wrVal[statBit(i) + 1];
      end
    end

    a_r2_set_sticky: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setStat[i] |=> statReg[i]);
    a_r3_hold_unless_ack: assert property (@(posedge clk) disable iff (!rstN)
      (statReg[i] && !strobes.clrStat[i]) |=> statReg[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstBit    <= 1'b0;
      asrBit    <= 1'b0;
      hltBit    <= 1'b1;
      initBit   <= 1'b0;
      audioClrQ <= 1'b0;
      padErrQ   <= 1'b0;
    end else begin
      if (strobes.wrStb) begin
        rstBit  <= strobes.wrVal[RST_BIT];
        asrBit  <= strobes.wrVal[ASR_BIT];
        hltBit  <= strobes.wrVal[HLT_BIT];
        initBit <= strobes.wrVal[INIT_BIT];
      end
      audioClrQ <= strobes.rstHit;
      padErrQ   <= strobes.padHit;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[RST_BIT]  = rstBit;
    rdData[ASR_BIT]  = asrBit;
    rdData[HLT_BIT]  = hltBit;
    rdData[INIT_BIT] = initBit;
    rdData[BUSY_BIT] = dmaBusy;
    for (int k = 0; k < SRC_N; k++) begin
      rdData[statBit(k)]     = statReg[k];
      rdData[statBit(k) + 1] = maskReg[k];
    end
  end

  assign irqOut      = |(statReg & maskReg);
  assign audioCtlClr = audioClrQ;
  assign padError    = padErrQ;

  a_r4_halt_written: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStb |=> (hltBit == $past(strobes.wrVal[HLT_BIT])));
  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|maskReg));
  a_r7_pad_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & PAD_MASK) == '0);
  a_r8_clear_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrStb && strobes.wrVal[RST_BIT]) |=> audioCtlClr);
  a_r7_pad_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrStb && |(strobes.wrVal & PAD_MASK)) |=> padError);
endmodule

// File: rtl/cop_irq_ctl.sv
module cop_irq_ctl
  import cop_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic [SRC_N-1:0] srcPulse,
  input  logic             dmaBusy,
  output logic             irqOut,
  output logic             audioCtlClr,
  output logic             padError
);
  ctlStrobes_t strobes;

  cop_irq_decode i_decode (
    .wrEn     (wrEn),
    .wrData   (wrData),
    .srcPulse (srcPulse),
    .strobes  (strobes)
  );

  cop_irq_datapath i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .dmaBusy     (dmaBusy),
    .rdData      (rdData),
    .irqOut      (irqOut),
    .audioCtlClr (audioCtlClr),
    .padError    (padError)
  );
endmodule

// File: tb/test_cop_irq_ctl.sv
module test_cop_irq_ctl;
  localparam logic [15:0] STAT_BITS = 16'h00A8;
  localparam logic [15:0] PAD_BITS  = 16'hF400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [2:0] srcPulse = '0;
  logic dmaBusy = 1'b0;
  logic [15:0] rdData;
  logic irqOut, audioCtlClr, padError;

  int nChecks = 0;
  int nFails = 0;
  logic [15:0] expReg;
  logic expClr, expPad;

  always #5 clk = ~clk;

  cop_irq_ctl i_cop_irq_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .srcPulse(srcPulse), .dmaBusy(dmaBusy), .irqOut(irqOut),
    .audioCtlClr(audioCtlClr), .padError(padError)
  );

  function automatic logic [15:0] pulseBits(input logic [2:0] p);
    return {8'h0, p[2], 1'b0, p[1], 1'b0, p[0], 3'b000};
  endfunction

  function automatic logic [15:0] nextReg(input logic [15:0] cur, input logic we,
                                          input logic [15:0] d, input logic [2:0] p);
    logic [15:0] n;
    if (we) begin
      n = (d & ~STAT_BITS & ~PAD_BITS & ~16'h0200) | ((cur & STAT_BITS) & ~(d & STAT_BITS));
    end else begin
      n = cur;
    end
    return n | pulseBits(p);
  endfunction

  function automatic logic expIrq(input logic [15:0] r);
    return |(((r >> 1) & r) & STAT_BITS);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check({req, " rdData"}, rdData, expReg | (dmaBusy ? 16'h0200 : 16'h0));
    check({req, " irqOut"}, {15'h0, irqOut}, {15'h0, expIrq(expReg)});
    check({req, " audioCtlClr"}, {15'h0, audioCtlClr}, {15'h0, expClr});
    check({req, " padError"}, {15'h0, padError}, {15'h0, expPad});
  endtask

  task automatic step(input string req, input logic we, input logic [15:0] d,
                      input logic [2:0] p, input logic busy);
    wrEn = we; wrData = d; srcPulse = p; dmaBusy = busy;
    expReg = nextReg(expReg, we, d, p);
    expClr = we & d[0];
    expPad = we & (|(d & PAD_BITS));
    @(posedge clk);
    @(negedge clk);
    checkAll(req);
    wrEn = 1'b0; srcPulse = '0;
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    expReg = 16'h0004; expClr = 1'b0; expPad = 1'b0;
    checkAll("R1 reset");
    // R2: set each source, sticky through idle cycles (R9)
    step("R2 set audio", 1'b0, 16'h0, 3'b001, 1'b0);
    step("R9 idle hold", 1'b0, 16'hFFFF, 3'b000, 1'b0);
    step("R2 set aux+cop", 1'b0, 16'h0, 3'b110, 1'b0);
    // R5: enable only the auxiliary source
    step("R5 enable aux", 1'b1, 16'h0040, 3'b000, 1'b0);
    // R3: write 0 to status keeps it; write 1 clears
    step("R3 zero write keeps", 1'b1, 16'h0000, 3'b000, 1'b0);
    step("R3 ack cop", 1'b1, 16'h0080, 3'b000, 1'b0);
    // R3: simultaneous set and clear leaves the bit set
    step("R3 set beats ack", 1'b1, 16'h0128, 3'b001, 1'b0);
    // R6: busy is live and not writable
    step("R6 busy shown", 1'b1, 16'h0200, 3'b000, 1'b1);
    step("R6 busy drops", 1'b0, 16'h0, 3'b000, 1'b0);
    // R7: padding write flagged, reads zero
    step("R7 pad write", 1'b1, 16'hF400, 3'b000, 1'b0);
    step("R7 pad quiet", 1'b0, 16'h0, 3'b000, 1'b0);
    // R4 and R8: control bits and audio clear
    step("R8 reset bit", 1'b1, 16'h0801, 3'b000, 1'b0);
    step("R4 controls", 1'b1, 16'h0806, 3'b000, 1'b0);
    step("R5 cop gated", 1'b1, 16'h0100, 3'b100, 1'b0);
    for (int n = 0; n < 600; n++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if (($urandom % 4) != 0) d = d & ~PAD_BITS;
      step("R4 random", (($urandom % 3) == 0), d, 3'($urandom & (($urandom % 2) == 0 ? 7 : 0)),
           1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule